// File: doc/BRIEF.md
# Programmable Bus-Clock Output Divider

This block derives a free-running output clock from the bus clock. One 8-bit control register sits on a simple register bus: an address, a write strobe, write data and combinational read data. The register holds an output-off bit, a divide field and a switch for a further fixed stage. Software writes the register at any time. The output then runs at the bus rate divided by (field + 1), and divided again by 16 when the extra stage is on. The output is held low while it is off.

Every path is synchronous to the bus clock. A new divide setting is copied into the divider only when an output period completes, so no period is ever cut short. For a total ratio of two or more, a reloading counter produces the output. Even ratios give a 50% duty cycle. Odd ratios give a high phase one bus cycle shorter than the low phase. For a total ratio of one, the bus clock is passed through an AND gate. A latch that is transparent while the clock is low enables that gate, so enabling or disabling the pass-through cannot glitch.

Top module: `clkout_divider`

## Requirements
- R1: After reset the register reads 0x80 (output off, field 0, extra stage off), and the output is low.
- R2: The register sits at address 0. It reads back at any time with layout {off[7], 0[6], stage16[5], field[4:0]}. Bit 6 always reads 0, so writing 0xFF reads back 0xBF. Any other address reads 0. A write to any other address leaves the register and the output unchanged.
- R3: Writing bit 7 = 1 forces the output low from the second bus-clock edge after the write edge on. The divider counters clear.
- R4: With bit 5 clear, the output period is (field + 1) bus cycles. For even ratios the output is high for the first half of the period and low for the second half.
- R5: For an odd total ratio T, the output is high for (T-1)/2 cycles and low for (T+1)/2 cycles.
- R6: With bit 5 set, the period becomes 16 × (field + 1) bus cycles, with the same duty rule.
- R7: With field 0 and bit 5 clear, the output follows the bus clock, high while it is high and low while it is low, from the second edge after the write edge on.
- R8: When the output is enabled from the off state, a period starts at the first edge after the write edge. The high phase comes first and counting restarts from zero.
- R9: A divide setting written while the output runs takes effect at the first period start that follows the write edge. The periods before it keep the old ratio in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register address |
| regWe | input | 1 | Write strobe, sampled on the rising edge |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the addressed register |
| clkOut | output | 1 | Divided output clock |

## Verification
A write registers on edge k. For a divided ratio, the first output high phase appears just after edge k+1. Output sample j after that is due at edge k+1+j and is high when (j mod T) < T/2. The bench therefore counts edges from the write edge and samples 2 ns after each rising edge. When a setting changes mid-run, the bench predicts the switch at the first multiple of the old ratio that is greater than the write's sample index. Turning the output off, and the pass-through ratio, both act from edge k+2, because the gate latch only opens during the low phase of the clock. Those checks begin at that edge and also sample the low half of each clock cycle.

// File: rtl/clkout_divider_pkg.sv
package clkout_divider_pkg;
  localparam int CTRL_W    = 8;
  localparam int DIV_W     = 5;
  localparam int POST_LOG2 = 4;
  localparam int TOT_W     = DIV_W + POST_LOG2 + 1;
  localparam int BIT_OFF   = 7;
  localparam int BIT_POST  = 5;

  typedef struct packed {
    logic             runEn;
    logic             bypass;
    logic [TOT_W-1:0] total;
    logic [TOT_W-1:0] half;
  } divCfg_t;
endpackage

// File: rtl/clkout_divider_ctrl.sv
module clkout_divider_ctrl
  import clkout_divider_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [CTRL_W-1:0] regWdata,
  output logic [CTRL_W-1:0] regRdata,
  output divCfg_t           cfg
);
  logic             offQ;
  logic             postQ;
  logic [DIV_W-1:0] divQ;
  logic             hit;
  logic [TOT_W-1:0] baseTotal;
  logic [TOT_W-1:0] fullTotal;

  assign hit = (regAddr == ADDR_W'(REG_ADDR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offQ  <= 1'b1;
      postQ <= 1'b0;
      divQ  <= '0;
    end else if (regWe && hit) begin
      offQ  <= regWdata[BIT_OFF];
      postQ <= regWdata[BIT_POST];
      divQ  <= regWdata[DIV_W-1:0];
    end
  end

  always_comb begin
    regRdata = '0;
    if (hit) begin
      regRdata[BIT_OFF]     = offQ;
      regRdata[BIT_POST]    = postQ;
      regRdata[DIV_W-1:0]   = divQ;
    end
  end

  assign baseTotal = TOT_W'(divQ) + TOT_W'(1);
  assign fullTotal = postQ ? (baseTotal << POST_LOG2) : baseTotal;

  always_comb begin
    cfg.runEn  = !offQ;
    cfg.total  = fullTotal;
    cfg.half   = fullTotal >> 1;
    cfg.bypass = (fullTotal == TOT_W'(1));
  end
endmodule

// File: rtl/clkout_divider_dp.sv
module clkout_divider_dp
  import clkout_divider_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  divCfg_t          cfg,
  output logic             clkOut,
  output logic [TOT_W-1:0] cntQ,
  output logic [TOT_W-1:0] actTotalQ,
  output logic             actBypassQ,
  output logic             runningQ,
  output logic             outQ,
  output logic             bypassOnQ
);
  logic [TOT_W-1:0] actHalfQ;
  logic             atEnd;
  logic             reload;
  logic [TOT_W-1:0] nextCnt;
  logic [TOT_W-1:0] nextTotal;
  logic [TOT_W-1:0] nextHalf;
  logic             nextBypass;
  logic             gateLat;

  assign atEnd  = actBypassQ || (cntQ == actTotalQ - TOT_W'(1));
  assign reload = !runningQ || atEnd;

  always_comb begin
    if (reload) begin
      nextCnt    = '0;
      nextTotal  = cfg.total;
      nextHalf   = cfg.half;
      nextBypass = cfg.bypass;
    end else begin
      nextCnt    = cntQ + TOT_W'(1);
      nextTotal  = actTotalQ;
      nextHalf   = actHalfQ;
      nextBypass = actBypassQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ       <= '0;
      actTotalQ  <= TOT_W'(1);
      actHalfQ   <= '0;
      actBypassQ <= 1'b1;
      runningQ   <= 1'b0;
      outQ       <= 1'b0;
      bypassOnQ  <= 1'b0;
    end else if (!cfg.runEn) begin
      cntQ       <= '0;
      actTotalQ  <= cfg.total;
      actHalfQ   <= cfg.half;
      actBypassQ <= cfg.bypass;
      runningQ   <= 1'b0;
      outQ       <= 1'b0;
      bypassOnQ  <= 1'b0;
    end else begin
      cntQ       <= nextCnt;
      actTotalQ  <= nextTotal;
      actHalfQ   <= nextHalf;
      actBypassQ <= nextBypass;
      runningQ   <= 1'b1;
      outQ       <= !nextBypass && (nextCnt < nextHalf);
      bypassOnQ  <= nextBypass;
    end
  end

  // gate enable only changes while the clock is low
  always_latch begin
    if (!rstN)     gateLat = 1'b0;
    else if (!clk) gateLat = bypassOnQ;
  end

  assign clkOut = (clk & gateLat) | outQ;
endmodule

// File: rtl/clkout_divider.sv
module clkout_divider
  import clkout_divider_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [CTRL_W-1:0] regWdata,
  output logic [CTRL_W-1:0] regRdata,
  output logic              clkOut
);
  divCfg_t          cfg;
  logic [TOT_W-1:0] cntQ;
  logic [TOT_W-1:0] actTotalQ;
  logic             actBypassQ;
  logic             runningQ;
  logic             outQ;
  logic             bypassOnQ;

  clkout_divider_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .cfg(cfg)
  );

  clkout_divider_dp dp_i (
    .clk(clk), .rstN(rstN), .cfg(cfg), .clkOut(clkOut),
    .cntQ(cntQ), .actTotalQ(actTotalQ), .actBypassQ(actBypassQ),
    .runningQ(runningQ), .outQ(outQ), .bypassOnQ(bypassOnQ)
  );
endmodule

// File: rtl/clkout_divider_chk.sv
module clkout_divider_chk
  import clkout_divider_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [CTRL_W-1:0] regRdata,
  input divCfg_t           cfg,
  input logic [TOT_W-1:0]  cntQ,
  input logic [TOT_W-1:0]  actTotalQ,
  input logic              actBypassQ,
  input logic              runningQ,
  input logic              outQ,
  input logic              bypassOnQ
);
  assert_bit6_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[6] == 1'b0);

  assert_off_cleared_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.runEn && $past(!cfg.runEn)) |-> (!outQ && !bypassOnQ && cntQ == '0));

  assert_cnt_in_period_R4: assert property (@(posedge clk) disable iff (!rstN)
    cntQ < actTotalQ);

  assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runningQ) |-> (cntQ == '0));

  assert_cfg_held_mid_period_R9: assert property (@(posedge clk) disable iff (!rstN)
    (runningQ && cfg.runEn && !actBypassQ && (cntQ != actTotalQ - TOT_W'(1)))
      |=> $stable(actTotalQ));
endmodule

bind clkout_divider clkout_divider_chk chk_i (
  .clk(clk), .rstN(rstN), .regRdata(regRdata), .cfg(cfg), .cntQ(cntQ),
  .actTotalQ(actTotalQ), .actBypassQ(actBypassQ), .runningQ(runningQ),
  .outQ(outQ), .bypassOnQ(bypassOnQ)
);

// File: tb/clkout_divider_tb.sv
module clkout_divider_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       clkOut;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  clkout_divider dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .clkOut(clkOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(posedge clk);
    #1 regWe = 1'b0; regAddr = '0;
  endtask

  task automatic readCheck(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #2 check(regRdata == exp, req, regRdata, exp);
    regAddr = '0;
  endtask

  // turn output off, wait until it has settled
  task automatic goOff();
    writeReg(4'd0, 8'h80);
    repeat (2) @(posedge clk);
    #2;
  endtask

  // enable with data d1 (ratio t1); optionally write d2 (ratio t2) at sample index chgAt
  task automatic observe(input logic [7:0] d1, input int t1, input int n, input string req,
                         input int chgAt, input logic [7:0] d2, input int t2);
    int j0;
    j0 = (chgAt < 0) ? n + 1 : ((chgAt / t1) + 1) * t1;
    writeReg(4'd0, d1);
    for (int j = 0; j < n; j++) begin
      int jj, tt;
      bit exp;
      @(negedge clk);
      if (j == chgAt) begin regAddr = 4'd0; regWdata = d2; regWe = 1'b1; end
      @(posedge clk);
      #1 regWe = 1'b0;
      #1;
      if (j >= j0) begin jj = j - j0; tt = t2; end
      else begin jj = j; tt = t1; end
      exp = ((jj % tt) < (tt / 2));
      check(clkOut == exp, req, clkOut, exp);
    end
    goOff();
  endtask

  task automatic testReset();
    readCheck(4'd0, 8'h80, "R1 reset value");
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2;
      check(clkOut == 1'b0, "R1 output low after reset", clkOut, 0);
    end
  endtask

  task automatic testRegister();
    writeReg(4'd0, 8'hFF);
    readCheck(4'd0, 8'hBF, "R2 bit6 reads zero");
    goOff();
    readCheck(4'd0, 8'h80, "R2 readback");
    readCheck(4'd3, 8'h00, "R2 other address reads zero");
    writeReg(4'd1, 8'h03);
    readCheck(4'd0, 8'h80, "R2 other address write ignored");
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #2;
      check(clkOut == 1'b0, "R2 output unchanged by other address", clkOut, 0);
    end
  endtask

  task automatic testEven();
    observe(8'h03, 4, 20, "R4 R8 divide by 4", -1, 8'h00, 1);
    observe(8'h1F, 32, 70, "R4 divide by 32", -1, 8'h00, 1);
    observe(8'h01, 2, 10, "R4 divide by 2", -1, 8'h00, 1);
  endtask

  task automatic testOdd();
    observe(8'h02, 3, 15, "R5 divide by 3", -1, 8'h00, 1);
    observe(8'h04, 5, 20, "R5 divide by 5", -1, 8'h00, 1);
  endtask

  task automatic testPost();
    observe(8'h20, 16, 40, "R6 post stage ratio 16", -1, 8'h00, 1);
    observe(8'h21, 32, 70, "R6 post stage ratio 32", -1, 8'h00, 1);
  endtask

  task automatic testBypass();
    writeReg(4'd0, 8'h00);
    @(posedge clk); // write edge + 1
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #2;
      check(clkOut == 1'b1, "R7 follows clock high", clkOut, 1);
      @(negedge clk); #2;
      check(clkOut == 1'b0, "R7 follows clock low", clkOut, 0);
    end
    writeReg(4'd0, 8'h80);
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2;
      check(clkOut == 1'b0, "R3 bypass off high phase", clkOut, 0);
      @(negedge clk); #2;
      check(clkOut == 1'b0, "R3 bypass off low phase", clkOut, 0);
    end
  endtask

  task automatic testDisable();
    writeReg(4'd0, 8'h01);
    repeat (5) @(posedge clk);
    writeReg(4'd0, 8'h80);
    @(posedge clk);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #2;
      check(clkOut == 1'b0, "R3 output held low", clkOut, 0);
    end
    observe(8'h03, 4, 8, "R8 restart after disable", -1, 8'h00, 1);
  endtask

  task automatic testChange();
    observe(8'h03, 4, 30, "R9 change 4 to 6", 5, 8'h05, 6);
    observe(8'h05, 6, 30, "R9 change 6 to 3", 2, 8'h02, 3);
    observe(8'h03, 4, 30, "R9 change written at boundary", 4, 8'h21, 32);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testRegister();
    testEven();
    testOdd();
    testPost();
    testBypass();
    testDisable();
    testChange();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule